// File: doc/BRIEF.md
# RAM Self-Test Access Port

This block lets a host bus reach a packet buffer RAM of 33-bit words directly, so that the RAM can be exercised by writing patterns and reading them back. Accesses do not use the bus address to choose a location. A single bus address acts as a data window, and an internal pointer picks the word. The pointer starts at zero after a clear and moves up by one on every accepted access, so a test walks the RAM in order.

A small status register, which has its own bus address, holds a test-enable bit, the value of the 33rd (packet-start) bit and a self-clearing clear bit. It also holds a sticky control-error flag. On a write the status register supplies the 33rd bit. On a read the stored 33rd bit is compared with the same status bit, and any difference is latched in the error flag. Reads of the data window and of the status register are registered, so their data appears one cycle after the strobe.

Top module: `tst_ram_port`

## Requirements
- R1: After reset, the test-enable bit, the 33rd-bit value and the error flag are 0, the pointer is 0 and `bus_rdata` is 0.
- R2: A data-window access happens only when test mode is enabled and `bus_addr` equals TEST_ADDR (0xC0). Any other strobe leaves the RAM and the pointer unchanged.
- R3: A window write stores `bus_wdata` in the low 32 bits of the word the pointer selects. It stores the status register's 33rd-bit value in bit 32.
- R4: A window read returns the low 32 bits of the selected word on `bus_rdata` in the cycle after the strobe. When no window or status read occurs, `bus_rdata` keeps its value.
- R5: The first access after a clear goes to location 0, and the n-th access goes to location n-1. Each read or write moves the pointer up by one.
- R6: After location DEPTH-1 is accessed, the pointer wraps to 0.
- R7: A window read whose stored bit 32 differs from the status register's 33rd-bit value sets the error flag. A read where the two bits match does not set it.
- R8: Once set, the error flag stays set until a clear, whatever later reads return.
- R9: A status write with bit 2 (clear) set resets the error flag and the pointer to 0 at that edge. Bit 2 always reads back as 0.
- R10: The status register is at STAT_ADDR (0x80), with bit 0 for test enable, bit 1 for the 33rd-bit value and bit 3 for the error flag (read only). A status write loads bits 0 and 1. A status read returns these fields, with all other bits 0, one cycle after the strobe.
- R11: When read and write strobes are both asserted, the access is treated as a write. `bus_rdata` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Host bus address |
| bus_wdata | input | DATA_W | Host write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | DATA_W | Registered read data |
| test_mode | output | 1 | Test-enable bit of the status register |
| ctl_err | output | 1 | Sticky control-bit mismatch flag |

## Verification
The bench builds the block with DEPTH set to 16. A full pass over the RAM and the wrap from the last location back to 0 then take only a few dozen accesses, so they are repeated many times during the random phase. The other parameters keep their defaults, so the window address 0xC0 and the status address 0x80 are exercised as they would be in use. Random sequences mix writes, reads, changes of the 33rd-bit value and clears, which makes matching and mismatching reads occur in many orders relative to the sticky flag.

// File: rtl/tst_pkg.sv
package tst_pkg;
  // Bit positions inside the status register word.
  localparam int ST_EN  = 0;
  localparam int ST_CTL = 1;
  localparam int ST_CLR = 2;
  localparam int ST_ERR = 3;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_WR   = 2'd1,
    ACC_RD   = 2'd2
  } acc_e;
endpackage

// File: rtl/tst_rst_sync.sv
module tst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/tst_status_reg.sv
module tst_status_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic wen_i,
  input  logic wctl_i,
  input  logic wclr_i,
  input  logic mism_i,
  output logic test_en_o,
  output logic ctl_val_o,
  output logic ctl_err_o,
  output logic clr_o
);
  logic en_q, en_d;
  logic ctl_q, ctl_d;
  logic err_q, err_d;

  always_comb begin
    en_d  = en_q;
    ctl_d = ctl_q;
    err_d = err_q;
    if (wr_i) begin
      en_d  = wen_i;
      ctl_d = wctl_i;
    end
    if (wr_i && wclr_i) err_d = 1'b0;
    else if (mism_i)    err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ctl_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      ctl_q <= ctl_d;
      err_q <= err_d;
    end
  end

  assign test_en_o = en_q;
  assign ctl_val_o = ctl_q;
  assign ctl_err_o = err_q;
  assign clr_o     = wr_i & wclr_i;
endmodule

// File: rtl/tst_addr_ctr.sv
module tst_addr_ctr #(
  parameter int DEPTH = 512,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clr_i)             ptr_d = '0;
    else if (step_i) begin
      if (ptr_q == LAST)   ptr_d = '0;
      else                 ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/tst_store.sv
module tst_store #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int WORD_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wctl_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[ptr_i] <= {wctl_i, wdata_i};
  end

  assign word_o = mem_q[ptr_i];
endmodule

// File: rtl/tst_ram_port.sv
module tst_ram_port
  import tst_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] TEST_ADDR = 8'hC0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              test_mode,
  output logic              ctl_err
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int WORD_W = DATA_W + 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic              rst_s;
  logic              test_en, ctl_val, clr;
  logic              stat_wr, stat_rd, mism;
  acc_e              acc;
  logic [PTR_W-1:0]  ptr;
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  tst_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s)
  );

  // Access decode: write wins over read on the same strobe.
  always_comb begin
    acc = ACC_NONE;
    if (test_en && bus_addr == TEST_ADDR) begin
      if (bus_wr)      acc = ACC_WR;
      else if (bus_rd) acc = ACC_RD;
    end
  end

  assign stat_wr = (bus_addr == STAT_ADDR) && bus_wr;
  assign stat_rd = (bus_addr == STAT_ADDR) && bus_rd && !bus_wr;

  tst_status_reg u_stat (
    .clk       (clk),
    .rst_n     (rst_s),
    .wr_i      (stat_wr),
    .wen_i     (bus_wdata[ST_EN]),
    .wctl_i    (bus_wdata[ST_CTL]),
    .wclr_i    (bus_wdata[ST_CLR]),
    .mism_i    (mism),
    .test_en_o (test_en),
    .ctl_val_o (ctl_val),
    .ctl_err_o (ctl_err),
    .clr_o     (clr)
  );

  tst_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_s),
    .clr_i  (clr),
    .step_i (acc != ACC_NONE),
    .ptr_o  (ptr)
  );

  tst_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .we_i    (acc == ACC_WR),
    .ptr_i   (ptr),
    .wdata_i (bus_wdata),
    .wctl_i  (ctl_val),
    .word_o  (word)
  );

  assign mism = (acc == ACC_RD) && (word[DATA_W] != ctl_val);

  always_comb begin
    stat_word         = '0;
    stat_word[ST_EN]  = test_en;
    stat_word[ST_CTL] = ctl_val;
    stat_word[ST_ERR] = ctl_err;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (acc == ACC_RD) rdata_d = word[DATA_W-1:0];
    else if (stat_rd)  rdata_d = stat_word;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign test_mode = test_en;

  // R9
  clr_resets_chk: assert property (@(posedge clk) disable iff (!rst_s)
    clr |=> (ptr == '0) && !ctl_err);

  // R6
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (acc != ACC_NONE) && (ptr == LAST) |=> ptr == '0);

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (acc != ACC_NONE) && (ptr != LAST) |=> ptr == PTR_W'($past(ptr) + 1'b1));

  // R2
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (acc == ACC_NONE) && !clr |=> $stable(ptr));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ctl_err && !clr |=> ctl_err);

  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (acc != ACC_RD) && !stat_rd |=> $stable(bus_rdata));

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_s)
    mism |=> ctl_err);
endmodule

// File: tb/sim_tst_ram_port.sv
module sim_tst_ram_port;
  localparam int DEPTH = 16;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam logic [AW-1:0] WIN  = 8'hC0;
  localparam logic [AW-1:0] STAT = 8'h80;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_wr, bus_rd;
  logic [DW-1:0] bus_rdata;
  logic test_mode, ctl_err;

  always #4 clk = ~clk;

  tst_ram_port #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .test_mode(test_mode), .ctl_err(ctl_err)
  );

  logic [32:0] mdl_mem [DEPTH];
  int mdl_ptr;
  bit mdl_en, mdl_ctl, mdl_err;
  logic [DW-1:0] last_rd;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic logic [DW-1:0] exp_status();
    return {28'd0, mdl_err, 1'b0, mdl_ctl, mdl_en};
  endfunction

  function automatic int next_ptr(int p);
    return (p == DEPTH - 1) ? 0 : p + 1;
  endfunction

  task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(logic [AW-1:0] a, logic [DW-1:0] d, logic w, logic r);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = r;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic st_write(bit en, bit ctl, bit clr);
    cyc(STAT, {29'd0, clr, ctl, en}, 1'b1, 1'b0);
    mdl_en = en; mdl_ctl = ctl;
    if (clr) begin mdl_ptr = 0; mdl_err = 1'b0; end
  endtask

  task automatic st_read(string req);
    cyc(STAT, '0, 1'b0, 1'b1);
    last_rd = exp_status();
    chk(req, bus_rdata, last_rd);
  endtask

  task automatic t_write(logic [DW-1:0] d);
    cyc(WIN, d, 1'b1, 1'b0);
    if (mdl_en) begin
      mdl_mem[mdl_ptr] = {mdl_ctl, d};
      mdl_ptr = next_ptr(mdl_ptr);
    end
  endtask

  task automatic t_read(string req);
    cyc(WIN, '0, 1'b0, 1'b1);
    if (mdl_en) begin
      last_rd = mdl_mem[mdl_ptr][31:0];
      if (mdl_mem[mdl_ptr][32] != mdl_ctl) mdl_err = 1'b1;
      mdl_ptr = next_ptr(mdl_ptr);
    end
    chk(req, bus_rdata, last_rd);
    chk("R7/R8 err flag", {31'd0, ctl_err}, {31'd0, mdl_err});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    mdl_ptr = 0; mdl_en = 1'b0; mdl_ctl = 1'b0; mdl_err = 1'b0; last_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 rdata", bus_rdata, '0);
    chk("R1 test_mode", {31'd0, test_mode}, '0);
    chk("R1 ctl_err", {31'd0, ctl_err}, '0);
    st_read("R1 status");

    // R2 window write while disabled is ignored
    t_write(32'hDEAD_0000);
    st_write(1'b1, 1'b0, 1'b1);
    chk("R10 test_mode set", {31'd0, test_mode}, 32'd1);
    for (int i = 0; i < DEPTH; i++) t_write(32'hA500_0000 + i);
    st_write(1'b0, 1'b0, 1'b0);
    t_write(32'hBAD0_0001);
    t_read("R2 read while disabled holds rdata");
    st_write(1'b1, 1'b0, 1'b0);
    cyc(8'hC4, 32'hBAD0_0002, 1'b1, 1'b0);   // R2 wrong address
    st_write(1'b1, 1'b0, 1'b1);
    // R3 R5 sequential readback, R6 wrap to location 0
    for (int i = 0; i < DEPTH; i++) t_read("R3/R5 readback");
    t_read("R6 wrap");

    // R7 mismatch, R8 sticky, R9 clear
    st_write(1'b1, 1'b1, 1'b1);
    t_write(32'h1111_1111);
    t_write(32'h2222_2222);
    st_write(1'b1, 1'b0, 1'b1);
    t_read("R7 mismatch sets err");
    st_write(1'b1, 1'b1, 1'b0);
    t_read("R8 matching read keeps err");
    st_read("R10 status shows err");
    st_write(1'b1, 1'b1, 1'b1);
    chk("R9 clear err", {31'd0, ctl_err}, '0);
    st_read("R9 clear bit reads 0");

    // R11 both strobes act as a write, rdata unchanged
    cyc(WIN, 32'h7777_7777, 1'b1, 1'b1);
    mdl_mem[mdl_ptr] = {mdl_ctl, 32'h7777_7777};
    mdl_ptr = next_ptr(mdl_ptr);
    chk("R11 rdata held", bus_rdata, last_rd);
    st_write(1'b1, 1'b1, 1'b1);
    t_read("R11 write taken");

    // Random phase
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 4)      t_write($urandom());
      else if (op < 8) t_read("R3/R4/R7 random read");
      else if (op < 9) st_write(1'b1, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0));
      else             st_read("R10 random status");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule